// File: doc/BRIEF.md
# Bit-Serial Authenticated Stream Cipher Engine

This block is a lightweight stream cipher engine that encrypts or decrypts one data bit per clock and ends each message with a 64-bit authentication tag. Its state is a 128-bit linear shift register and a 128-bit nonlinear shift register. A start strobe loads both registers from a 128-bit key and a 96-bit IV. The engine then mixes the state for 256 clocks and produces no output during that time. After mixing, each accepted data bit is XORed with the current keystream bit. The state advances only when a bit is accepted.

Each ciphertext bit is folded back into the linear register's feedback. This ties the final state to the whole message. In encrypt mode the ciphertext is the output stream; in decrypt mode it is the input stream. Both ends therefore build the same state from the same key, IV and ciphertext. After the end-of-message strobe, the engine runs 64 more clocks and shifts the keystream bits into the tag register. It then raises a one-clock done flag. The tag stays on the output until the next start.

Top module: `grn_stream_mac`

## Requirements
- R1: A start pulse loads the nonlinear register with the key. Bits 0..95 of the linear register take the IV, bits 96..126 are set to 1 and bit 127 is cleared. The tag register is cleared in the same clock.
- R2: After a start, the engine runs exactly 256 mixing steps. In each step the keystream bit is XORed into the feedback of both registers. `din_ready` stays low and `dout_valid` stays low throughout, even while `din_valid` is high.
- R3: The keystream bit z is `b12&s8 ^ s13&s20 ^ b95&s42 ^ s60&s79 ^ b12&b95&s94 ^ s93 ^ b2^b15^b36^b45^b64^b73^b89`, where b is the nonlinear register and s is the linear register. When a bit is accepted, `dout = din ^ z` in the same cycle and `dout_valid` is high.
- R4: The linear feedback is `s0^s7^s38^s70^s81^s96`. The nonlinear feedback is s0 XOR the nonlinear function g of b. Both registers shift towards bit 0 and take the feedback into bit 127. The state advances only on a cycle where a bit is accepted; otherwise it holds.
- R5: Each accepted bit's ciphertext is XORed into the linear feedback. The ciphertext is `dout` when `decrypt` is 0 and `din` when `decrypt` is 1. Decrypting a ciphertext therefore returns the plaintext and the same tag.
- R6: When `eom` is high in the data phase, the bit accepted in that cycle (if any) is the last one. The engine then runs 64 tag steps with no feedback injection. Each step's z is shifted into the tag from bit 0, so the first tag bit ends in `mac[63]`.
- R7: `done` is high for exactly one cycle, 64 clocks after the `eom` edge. From then on, `mac` holds its value until the next start.
- R8: A start pulse in any phase, including the data and tag phases, abandons the current work and begins a fresh load. No `done` is raised for the abandoned message.
- R9: After reset, `din_ready`, `dout_valid`, `done` and `mac` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load key and IV and begin mixing |
| key | input | 128 | Secret key, sampled at start |
| iv | input | 96 | Initialization vector, sampled at start |
| decrypt | input | 1 | 1: input stream is ciphertext; 0: input stream is plaintext |
| din_valid | input | 1 | Data bit offered |
| din | input | 1 | Serial data bit in |
| din_ready | output | 1 | Engine can accept a data bit this cycle |
| dout_valid | output | 1 | Output bit valid (bit accepted this cycle) |
| dout | output | 1 | Serial data bit out, din XOR keystream |
| eom | input | 1 | End of message; starts the tag phase |
| mac | output | 64 | Authentication tag |
| done | output | 1 | One-cycle pulse when the tag is complete |

## Verification
The interesting collision is `eom` arriving in the same cycle as the final valid data bit. The engine must encrypt and absorb that bit, and also move into the tag phase. The bench sends some messages that way and others with a separate `eom` cycle. It checks both the output bit of that cycle and the final tag against a bench model. A second collision is a start pulse that lands while a message is being streamed or its tag is being built. Here the bench checks that no done pulse leaks out and that the following message matches a clean run.

// File: rtl/grn_pkg.sv
package grn_pkg;

    localparam int REG_W = 128;
    localparam int KEY_W = 128;
    localparam int IV_W  = 96;
    localparam int PAD_W = REG_W - IV_W - 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INIT,
        PH_DATA,
        PH_TAG
    } phase_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_MIX,
        OP_RUN
    } step_t;

    typedef struct packed {
        logic [REG_W-1:0] nl;
        logic [REG_W-1:0] ln;
    } core_t;

    function automatic logic lin_fb(input logic [REG_W-1:0] s);
        return s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96];
    endfunction

    function automatic logic nl_fn(input logic [REG_W-1:0] b);
        return b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96]
             ^ (b[3] & b[67]) ^ (b[11] & b[13]) ^ (b[17] & b[18])
             ^ (b[27] & b[59]) ^ (b[40] & b[48]) ^ (b[61] & b[65])
             ^ (b[68] & b[84]) ^ (b[88] & b[92] & b[93] & b[95])
             ^ (b[22] & b[24] & b[25]) ^ (b[70] & b[78] & b[82]);
    endfunction

    function automatic logic ks_fn(input core_t c);
        logic hx;
        hx = (c.nl[12] & c.ln[8]) ^ (c.ln[13] & c.ln[20]) ^ (c.nl[95] & c.ln[42])
           ^ (c.ln[60] & c.ln[79]) ^ (c.nl[12] & c.nl[95] & c.ln[94]);
        return hx ^ c.ln[93] ^ c.nl[2] ^ c.nl[15] ^ c.nl[36] ^ c.nl[45]
             ^ c.nl[64] ^ c.nl[73] ^ c.nl[89];
    endfunction

endpackage

// File: rtl/grn_core.sv
module grn_core
    import grn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_t            op,
    input  logic [KEY_W-1:0] key,
    input  logic [IV_W-1:0]  iv,
    input  logic             inj,
    output logic             ks,
    output core_t            st
);

    logic ln_in;
    logic nl_in;

    always_comb begin
        ks    = ks_fn(st);
        ln_in = lin_fb(st.ln);
        nl_in = st.ln[0] ^ nl_fn(st.nl);
        if (op == OP_MIX) begin
            ln_in = ln_in ^ ks;
            nl_in = nl_in ^ ks;
        end else if (op == OP_RUN) begin
            ln_in = ln_in ^ inj;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    st.nl <= key;
                    st.ln <= {1'b0, {PAD_W{1'b1}}, iv};
                end
                OP_MIX, OP_RUN: begin
                    st.nl <= {nl_in, st.nl[REG_W-1:1]};
                    st.ln <= {ln_in, st.ln[REG_W-1:1]};
                end
                default: st <= st;
            endcase
        end
    end

endmodule

// File: rtl/grn_ctrl.sv
module grn_ctrl
    import grn_pkg::*;
#(
    parameter int INIT_STEPS = 256,
    parameter int TAG_W      = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   din_valid,
    input  logic   eom,
    output phase_t phase,
    output step_t  op,
    output logic   acc_ok,
    output logic   tag_shift,
    output logic   done
);

    localparam int MAXC  = (INIT_STEPS > TAG_W) ? INIT_STEPS : TAG_W;
    localparam int CNT_W = $clog2(MAXC);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        acc_ok    = (phase == PH_DATA) && !start;
        tag_shift = (phase == PH_TAG) && !start;
        if (start)                              op = OP_LOAD;
        else if (phase == PH_INIT)              op = OP_MIX;
        else if (phase == PH_TAG)               op = OP_RUN;
        else if (phase == PH_DATA && din_valid) op = OP_RUN;
        else                                    op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= PH_INIT;
                cnt   <= '0;
            end else begin
                case (phase)
                    PH_INIT: begin
                        if (cnt == CNT_W'(INIT_STEPS - 1)) begin
                            phase <= PH_DATA;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (eom) begin
                            phase <= PH_TAG;
                            cnt   <= '0;
                        end
                    end
                    PH_TAG: begin
                        if (cnt == CNT_W'(TAG_W - 1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/grn_tag.sv
module grn_tag #(
    parameter int TAG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [TAG_W-1:0] tag
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tag <= '0;
        end else if (shift) begin
            tag <= {tag[TAG_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/grn_stream_mac.sv
module grn_stream_mac
    import grn_pkg::*;
#(
    parameter int INIT_STEPS = 256,
    parameter int TAG_W      = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [127:0]     key,
    input  logic [95:0]      iv,
    input  logic             decrypt,
    input  logic             din_valid,
    input  logic             din,
    output logic             din_ready,
    output logic             dout_valid,
    output logic             dout,
    input  logic             eom,
    output logic [TAG_W-1:0] mac,
    output logic             done
);

    phase_t phase;
    step_t  op;
    core_t  st;
    logic   ks;
    logic   acc_ok;
    logic   tag_shift;
    logic   ct_bit;

    grn_ctrl #(.INIT_STEPS(INIT_STEPS), .TAG_W(TAG_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din_valid (din_valid),
        .eom       (eom),
        .phase     (phase),
        .op        (op),
        .acc_ok    (acc_ok),
        .tag_shift (tag_shift),
        .done      (done)
    );

    grn_core u_core (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .key (key),
        .iv  (iv),
        .inj (ct_bit),
        .ks  (ks),
        .st  (st)
    );

    grn_tag #(.TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .shift  (tag_shift),
        .bit_in (ks),
        .tag    (mac)
    );

    always_comb begin
        din_ready  = acc_ok;
        dout_valid = acc_ok && din_valid;
        dout       = din ^ ks;
        ct_bit     = (phase == PH_DATA) && dout_valid && (decrypt ? din : dout);
    end

endmodule

// File: rtl/grn_checker.sv
module grn_checker
    import grn_pkg::*;
#(
    parameter int INIT_STEPS = 256,
    parameter int TAG_W      = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             din_valid,
    input logic             din_ready,
    input logic             eom,
    input logic             done,
    input logic [TAG_W-1:0] mac,
    input core_t            st
);

    localparam int CW = $clog2(INIT_STEPS + TAG_W) + 2;

    logic [CW-1:0] since_start;
    logic [CW-1:0] since_eom;
    logic          after_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= '0;
            since_eom   <= '0;
            after_done  <= 1'b0;
        end else begin
            if (start)                         since_start <= '0;
            else if (since_start != {CW{1'b1}}) since_start <= since_start + 1'b1;
            if (eom && din_ready)              since_eom <= '0;
            else if (since_eom != {CW{1'b1}})  since_eom <= since_eom + 1'b1;
            if (start)     after_done <= 1'b0;
            else if (done) after_done <= 1'b1;
        end
    end

    a_r2_ready_low_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> !din_ready);

    a_r2_init_length: assert property (@(posedge clk) disable iff (rst)
        $rose(din_ready) |-> (since_start == CW'(INIT_STEPS)));

    a_r4_hold_without_data: assert property (@(posedge clk) disable iff (rst)
        (din_ready && !din_valid && !eom && !start) |=> $stable(st));

    a_r6_done_timing: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_eom == CW'(TAG_W)) && !din_ready);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_mac_held: assert property (@(posedge clk) disable iff (rst)
        (after_done && !start) |=> $stable(mac));

endmodule

bind grn_stream_mac grn_checker #(.INIT_STEPS(INIT_STEPS), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .eom       (eom),
    .done      (done),
    .mac       (mac),
    .st        (st)
);

// File: tb/tb_grn_stream_mac.sv
module tb_grn_stream_mac;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] key;
    logic [95:0]  iv;
    logic         decrypt;
    logic         din_valid;
    logic         din;
    logic         din_ready;
    logic         dout_valid;
    logic         dout;
    logic         eom;
    logic [63:0]  mac;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    bit          din_a [0:127];
    bit          exp_o [0:127];
    logic [63:0] exp_tag;

    always #5 clk = ~clk;

    grn_stream_mac dut (
        .clk(clk), .rst(rst), .start(start), .key(key), .iv(iv),
        .decrypt(decrypt), .din_valid(din_valid), .din(din),
        .din_ready(din_ready), .dout_valid(dout_valid), .dout(dout),
        .eom(eom), .mac(mac), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_lin(input logic [127:0] s);
        return s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96];
    endfunction

    function automatic bit m_g(input logic [127:0] b);
        return b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96] ^ (b[3] & b[67]) ^ (b[11] & b[13])
             ^ (b[17] & b[18]) ^ (b[27] & b[59]) ^ (b[40] & b[48]) ^ (b[61] & b[65])
             ^ (b[68] & b[84]) ^ (b[88] & b[92] & b[93] & b[95]) ^ (b[22] & b[24] & b[25])
             ^ (b[70] & b[78] & b[82]);
    endfunction

    function automatic bit m_z(input logic [127:0] b, input logic [127:0] s);
        return (b[12] & s[8]) ^ (s[13] & s[20]) ^ (b[95] & s[42]) ^ (s[60] & s[79])
             ^ (b[12] & b[95] & s[94]) ^ s[93] ^ b[2] ^ b[15] ^ b[36] ^ b[45]
             ^ b[64] ^ b[73] ^ b[89];
    endfunction

    // Reference model: fills exp_o and exp_tag from din_a
    task automatic model(input logic [127:0] k, input logic [95:0] v, input bit dec, input int n);
        logic [127:0] b, s;
        bit z, o, ct, fl, fn;
        b = k;
        s = {1'b0, {31{1'b1}}, v};
        for (int i = 0; i < 256; i++) begin
            z  = m_z(b, s);
            fl = m_lin(s) ^ z;
            fn = s[0] ^ m_g(b) ^ z;
            s = {fl, s[127:1]};
            b = {fn, b[127:1]};
        end
        for (int i = 0; i < n; i++) begin
            z  = m_z(b, s);
            o  = din_a[i] ^ z;
            exp_o[i] = o;
            ct = dec ? din_a[i] : o;
            fl = m_lin(s) ^ ct;
            fn = s[0] ^ m_g(b);
            s = {fl, s[127:1]};
            b = {fn, b[127:1]};
        end
        exp_tag = '0;
        for (int i = 0; i < 64; i++) begin
            z  = m_z(b, s);
            exp_tag = {exp_tag[62:0], z};
            fl = m_lin(s);
            fn = s[0] ^ m_g(b);
            s = {fl, s[127:1]};
            b = {fn, b[127:1]};
        end
    endtask

    task automatic do_start(input logic [127:0] k, input logic [95:0] v, input bit dec);
        @(negedge clk);
        key = k; iv = v; decrypt = dec; start = 1'b1; din_valid = 1'b0; eom = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_init();
        int cnt = 0;
        din_valid = 1'b1;
        din = 1'($urandom);
        while (!din_ready && cnt < 400) begin
            #1;
            check(dout_valid == 1'b0, "R2 dout_valid in init", 64'(dout_valid), 64'd0);
            cnt++;
            @(negedge clk);
        end
        check(cnt == 256, "R2 init length", 64'(cnt), 64'd256);
        din_valid = 1'b0;
    endtask

    task automatic run_msg(input logic [127:0] k, input logic [95:0] v, input bit dec,
                           input int n, input bit eom_last, input int gap);
        int cnt;
        bit eom_sent;
        model(k, v, dec, n);
        do_start(k, v, dec);
        wait_init();
        eom_sent = 0;
        for (int i = 0; i < n; i++) begin
            while (int'($urandom % 100) < gap) begin
                din_valid = 1'b0; eom = 1'b0;
                @(negedge clk);
            end
            din_valid = 1'b1;
            din = din_a[i];
            eom = (i == n - 1) && eom_last;
            eom_sent = eom;
            #1;
            check(dout_valid && dout == exp_o[i], "R3 R5 R6 dout bit", 64'({dout_valid, dout}), 64'({1'b1, exp_o[i]}));
            @(negedge clk);
        end
        din_valid = 1'b0;
        if (!eom_sent) begin
            eom = 1'b1;
            @(negedge clk);
        end
        eom = 1'b0;
        cnt = 0;
        while (!done && cnt < 200) begin
            din_valid = 1'($urandom);
            #1;
            check(!din_ready && !dout_valid, "R6 no data in tag phase", 64'({din_ready, dout_valid}), 64'd0);
            cnt++;
            @(negedge clk);
        end
        din_valid = 1'b0;
        check(cnt == 64, "R7 done latency", 64'(cnt), 64'd64);
        check(mac == exp_tag, "R6 tag value", mac, exp_tag);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        check(mac == exp_tag, "R7 tag held", mac, exp_tag);
    endtask

    task automatic abort_msg(input logic [127:0] k, input logic [95:0] v, input int n, input bit into_tag);
        bit seen = 0;
        do_start(k, v, 1'b0);
        wait_init();
        for (int i = 0; i < n; i++) begin
            din_valid = 1'b1; din = 1'($urandom);
            @(negedge clk);
        end
        din_valid = 1'b0;
        if (into_tag) begin
            eom = 1'b1;
            @(negedge clk);
            eom = 1'b0;
            repeat (20) begin
                if (done) seen = 1;
                @(negedge clk);
            end
        end
        check(!seen, "R8 no done before restart", 64'(seen), 64'd0);
    endtask

    logic [63:0] tag1;
    bit          ct_save [0:127];

    initial begin
        logic [127:0] k;
        logic [95:0]  v;
        void'($urandom(32'd20250));
        rst = 1'b1; start = 1'b0; key = '0; iv = '0; decrypt = 1'b0;
        din_valid = 1'b0; din = 1'b0; eom = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!din_ready && !dout_valid && !done && mac == 0, "R9 reset state",
              {mac[60:0], din_ready, dout_valid, done}, 64'd0);
        rst = 1'b0;

        // R1 R3 R5 R6: encrypt, eom together with the last bit
        k = {$urandom, $urandom, $urandom, $urandom};
        v = {$urandom, $urandom, $urandom};
        for (int i = 0; i < 48; i++) din_a[i] = 1'($urandom);
        run_msg(k, v, 1'b0, 48, 1'b1, 30);
        tag1 = exp_tag;
        for (int i = 0; i < 48; i++) ct_save[i] = exp_o[i];

        // R5: decrypt the ciphertext, separate eom cycle
        for (int i = 0; i < 48; i++) din_a[i] = ct_save[i];
        run_msg(k, v, 1'b1, 48, 1'b0, 0);
        check(mac == tag1, "R5 decrypt tag equals encrypt tag", mac, tag1);

        // R6: empty message
        run_msg(k, v, 1'b0, 0, 1'b0, 0);

        // R8: restart during data phase and during tag phase
        abort_msg(~k, v, 5, 1'b0);
        for (int i = 0; i < 20; i++) din_a[i] = 1'($urandom);
        run_msg(k, ~v, 1'b0, 20, 1'b1, 10);
        abort_msg(k, ~v, 3, 1'b1);
        run_msg(k, v, 1'b1, 20, 1'b0, 20);

        // R1: all-zero key and IV
        for (int i = 0; i < 16; i++) din_a[i] = 1'b0;
        run_msg('0, '0, 1'b0, 16, 1'b0, 0);

        // R3 R4: random messages
        for (int t = 0; t < 6; t++) begin
            int n;
            k = {$urandom, $urandom, $urandom, $urandom};
            v = {$urandom, $urandom, $urandom};
            n = 1 + int'($urandom % 100);
            for (int i = 0; i < n; i++) din_a[i] = 1'($urandom);
            run_msg(k, v, 1'($urandom), n, 1'($urandom), int'($urandom % 50));
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule